// File: doc/BRIEF.md
# Idle Wake Interval Timer

This block keeps a 16-bit down counter running for as long as the chip is out of reset. The counter steps once on every cycle that carries the single-cycle instruction tick. Each time the decrement changes bit 12 of the counter, the block records an event. Bit 12 is the thirteenth bit, counting from bit 0. This gives one event every 4096 ticks, set by the arithmetic of the borrow chain rather than by any compare register.

Software sees a two-bit control word and nothing else. The word holds a pending flag and an interrupt enable. The counter cannot be read, loaded or paused through it. The interrupt request is the pending flag gated by the enable. A separate one-cycle wake pulse fires on every event, whatever the enable setting, so that a low-power controller can leave its idle state. After reset the counter starts from a parameter value. Software may rely only on the event spacing, never on the phase of the first event.

Top module: `iwt_idle_wake_timer`

## Requirements
- R1: While reset is asserted and at the first clock after its release, reg_rdata_o is 2'b00, irq_o is 0 and wake_o is 0, and the counter holds START_VALUE.
- R2: The counter decreases by exactly one, wrapping from 0 to 16'hFFFF, on each rising clock edge where tick_i is high. It holds its value on every other edge.
- R3: A tick whose decrement changes counter bit 12 sets the pending flag, which is reg_rdata_o bit 0, at that same edge. Such ticks are exactly 4096 ticks apart.
- R4: wake_o is high for exactly the one clock cycle after each edge at which bit 12 changes, whatever the enable value.
- R5: irq_o is high exactly when both the pending flag and the enable flag are set.
- R6: A register write (reg_wr_i high) with reg_wdata_i bit 0 equal to 0 clears the pending flag at that edge. Writing 1 to bit 0 does not set the flag. If a bit-12 change happens at the same edge, the flag is set and stays set.
- R7: A register write loads the enable flag from reg_wdata_i bit 1. The flag is read back on reg_rdata_o bit 1.
- R8: Register writes have no effect on the counter, so the spacing of events is unchanged by any write traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle instruction tick; the counter steps only when this is high |
| reg_wr_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 2 | Write data: bit 1 is the enable, bit 0 is written 0 to clear the pending flag |
| reg_rdata_o | output | 2 | Read data: bit 1 is the enable, bit 0 is the pending flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | One-cycle wake pulse on every bit-12 event |

## Verification
Each result has a fixed latency after its stimulus:
- A tick or write sampled at a rising edge changes the pending and enable bits in the register state at that same edge.
- irq_o follows those bits in the same cycle, with no further delay.
- wake_o is the registered copy of the event and so is high during the cycle right after the triggering edge.

The bench steps its own behavioural model at each rising edge from the same inputs. It compares every output at the following falling edge, where all of these values have settled. It drives new inputs only after that comparison. A separate tick count taken between observed wake pulses confirms the 4096-tick spacing under gapped tick patterns and write traffic.

// File: rtl/iwt_pkg.sv
package iwt_pkg;

  localparam int unsigned IWT_RD_W    = 2;
  localparam int unsigned IWT_PEND_IX = 0;
  localparam int unsigned IWT_EN_IX   = 1;

  // True when decrementing the value by one changes the chosen bit.
  function automatic logic tap_flips(input logic [31:0] value, input int unsigned tap);
    logic [31:0] dec;
    dec = value - 32'd1;
    return value[tap] != dec[tap];
  endfunction

  // Next counter value for a down counter that steps only on a tick.
  function automatic logic [31:0] step_down(input logic [31:0] value, input logic tick);
    return tick ? (value - 32'd1) : value;
  endfunction

endpackage

// File: rtl/iwt_counter.sv
module iwt_counter #(
  parameter int unsigned CNT_W       = 16,
  parameter logic [CNT_W-1:0] START_VALUE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  import iwt_pkg::*;

  logic [CNT_W-1:0] count_q;
  logic [31:0]      next_wide;

  always_comb next_wide = step_down(32'(count_q), tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= START_VALUE;
    else         count_q <= next_wide[CNT_W-1:0];
  end

  assign count_o = count_q;

  // R2: one step down per tick, wrapping
  a_r2_step_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (count_o == CNT_W'($past(count_o) - 1'b1)));

  // R2: no movement without a tick
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_o));

endmodule

// File: rtl/iwt_toggle_detect.sv
module iwt_toggle_detect #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TAP   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             toggle_o,
  output logic             wake_o
);
  import iwt_pkg::*;

  logic wake_q;

  always_comb toggle_o = tick_i && tap_flips(32'(count_i), TAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= toggle_o;
  end

  assign wake_o = wake_q;

  // R3: a flagged event really changes the tap bit at that edge
  a_r3_tap_changes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_o |=> (count_i[TAP] != $past(count_i[TAP])));

  // R4: wake pulse lasts a single cycle
  a_r4_wake_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  // R4: every event produces a wake pulse
  a_r4_wake_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_o |=> wake_o);

endmodule

// File: rtl/iwt_flags.sv
module iwt_flags
  import iwt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                event_i,
  input  logic                wr_i,
  input  logic [IWT_RD_W-1:0] wdata_i,
  output logic [IWT_RD_W-1:0] rdata_o,
  output logic                irq_o
);

  logic pend_q, en_q;
  logic clear_req;

  always_comb clear_req = wr_i && !wdata_i[IWT_PEND_IX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (event_i)        pend_q <= 1'b1;
      else if (clear_req) pend_q <= 1'b0;
      if (wr_i)           en_q   <= wdata_i[IWT_EN_IX];
    end
  end

  always_comb begin
    rdata_o              = '0;
    rdata_o[IWT_PEND_IX] = pend_q;
    rdata_o[IWT_EN_IX]   = en_q;
  end

  assign irq_o = pend_q & en_q;

  // R3 and R6: an event always leaves the flag set, even against a clear
  a_r3_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> rdata_o[IWT_PEND_IX]);

  // R6: a clear without an event drops the flag
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[IWT_PEND_IX] && !event_i) |=> !rdata_o[IWT_PEND_IX]);

  // R6: the flag never rises without an event
  a_r6_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !event_i |=> !$rose(rdata_o[IWT_PEND_IX]));

  // R7: enable takes the written value
  a_r7_enable_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (rdata_o[IWT_EN_IX] == $past(wdata_i[IWT_EN_IX])));

endmodule

// File: rtl/iwt_idle_wake_timer.sv
module iwt_idle_wake_timer #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned TAP         = 12,
  parameter logic [CNT_W-1:0] START_VALUE = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       reg_wr_i,
  input  logic [1:0] reg_wdata_i,
  output logic [1:0] reg_rdata_o,
  output logic       irq_o,
  output logic       wake_o
);
  import iwt_pkg::*;

  logic [CNT_W-1:0] count_w;
  logic             tap_event_w;

  iwt_counter #(.CNT_W(CNT_W), .START_VALUE(START_VALUE)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .count_o (count_w)
  );

  iwt_toggle_detect #(.CNT_W(CNT_W), .TAP(TAP)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .count_i  (count_w),
    .toggle_o (tap_event_w),
    .wake_o   (wake_o)
  );

  iwt_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (tap_event_w),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .irq_o   (irq_o)
  );

  // R8: a write never moves the counter on a cycle without a tick
  a_r8_write_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !tick_i) |=> $stable(count_w));

  // R5: interrupt needs the enable
  a_r5_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[IWT_EN_IX] |-> !irq_o);

endmodule

// File: tb/iwt_idle_wake_timer_bench.sv
module iwt_idle_wake_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] START = 16'h1005;
  localparam int RUN_CYCLES = 14000;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr = 1'b0;
  logic [1:0] wdata = 2'b00;
  logic [1:0] rdata;
  logic irq, wake;

  int compared = 0, mismatched = 0;

  // behavioural reference state
  int  m_cnt = int'(START);
  bit  m_pend = 0, m_en = 0, m_wake = 0;
  int  ticks_since = 0;
  bit  seen_wake = 0;
  bit  collide_done = 0;
  bit  finished = 0;

  iwt_idle_wake_timer #(.CNT_W(16), .TAP(12), .START_VALUE(START)) u_iwt_idle_wake_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model step: 16-bit wrap, event when bit 12 changes on a tick
  always @(posedge clk) if (rst_n) begin
    int nxt;
    bit ev;
    nxt = tick ? ((m_cnt + 65535) % 65536) : m_cnt;
    ev  = tick && (((m_cnt / 4096) % 2) != ((nxt / 4096) % 2));
    if (ev) m_pend = 1;
    else if (wr && !wdata[0]) m_pend = 0;
    if (wr) m_en = wdata[1];
    m_wake = ev;
    m_cnt = nxt;
    if (tick) ticks_since++;
  end

  function automatic bit tick_pattern(input int cyc);
    if (cyc < 5000) return 1'b1;
    return (cyc % 3) != 2;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(rdata == 2'b00, "R1 rdata in reset", rdata, 0);
    check(irq == 0, "R1 irq in reset", irq, 0);
    check(wake == 0, "R1 wake in reset", wake, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: first cycle after release
    check(rdata == 2'b00, "R1 rdata after release", rdata, 0);
    check(wake == 0, "R1 wake after release", wake, 0);
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      bit t;
      t = tick_pattern(cyc);
      tick = t;
      wr = 1'b0;
      wdata = 2'b00;
      if (cyc == 100)  begin wr = 1; wdata = 2'b10; end // R7 enable on
      if (cyc == 200)  begin wr = 1; wdata = 2'b10; end // R6 clear, keep enable
      if (cyc == 300)  begin wr = 1; wdata = 2'b11; end // R6 writing 1 does not set
      if (cyc == 6000) begin wr = 1; wdata = 2'b01; end // R7 enable off
      if (cyc == 6500) begin wr = 1; wdata = 2'b00; end // R6 clear with enable off
      if (cyc % 97 == 5) begin wr = 1; wdata = {m_en, 1'b1}; end // R8 write traffic
      // R6: clear colliding with an event
      if (!collide_done && cyc > 3000 && t && (m_cnt % 4096) == 0) begin
        wr = 1; wdata = {m_en, 1'b0}; collide_done = 1;
      end
      @(negedge clk);
      check(rdata[0] == m_pend, "R3/R6 pending", rdata[0], m_pend);
      check(rdata[1] == m_en, "R7 enable", rdata[1], m_en);
      check(irq == (m_pend && m_en), "R5 irq", irq, m_pend && m_en);
      check(wake == m_wake, "R4 wake", wake, m_wake);
      if (wake) begin
        // R2/R3/R8: spacing counted from the ticks applied
        if (!seen_wake) check(ticks_since == 6, "R1 first event phase", ticks_since, 6);
        else check(ticks_since == 4096, "R3 event spacing", ticks_since, 4096);
        seen_wake = 1;
        ticks_since = 0;
      end
    end
    check(collide_done == 1, "R6 collision exercised", collide_done, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, RUN_CYCLES);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule